// File: doc/BRIEF.md
# Inactivity Timer Clock Manager

This block watches system activity and steps the CPU clock down when the system has been idle long enough. It holds two count-down timers, A and B. Both advance from one shared base strobe, which is derived from an external tick by a programmable divider. Each timer also divides that strobe further with its own prescaler. Any activity event that is enabled in a timer's reload mask restarts that timer from its programmed count. When timer A runs out, it can put the clock into slow mode. When timer B runs out, it can stop the clock. Either expiry can also raise an interrupt.

A second mask per timer selects the wake events. A timer A wake event returns the clock to full speed. A timer B wake event restarts a stopped clock at whichever speed was selected before the stop. This is slow if timer A had slowed the clock, and full otherwise. Every expiry and every wake sets a sticky status bit. Software clears a status bit by writing 1 to it.

Software programs the block through a write port with a 3-bit address and a 16-bit data word. Address map:

| Address | Contents |
|---|---|
| 0 | Base divider in data[3:0] |
| 1 | Timer A configuration |
| 2 | Timer A reload mask |
| 3 | Timer A wake mask |
| 4 | Timer B configuration |
| 5 | Timer B reload mask in data[7:0], timer B wake mask in data[15:8] |
| 6 | Status clear, write 1 to a bit to clear it |

Top module: `idle_clk_mgr`

## Requirements
- R1: After reset, clk_mode_o is 0 (full speed), clk_stop_o is 0, irq_o is 0 and status_o is 0.
- R2: The base strobe fires once every (D+1) cycles with tick_i high, where D is the value in register 0. A timer with prescaler P decrements once every (P+1) base strobes. A timeout therefore spans count×(P+1)×(D+1) tick pulses. Writing register 0 restarts the base divider phase.
- R3: The configuration words at addresses 1 and 4 use these fields: data[7:0] is the count, data[11:8] is the prescaler, data[12] enables the low-power action, data[13] enables the interrupt on expiry, and data[14] enables the interrupt on wake. Writing a configuration word loads the counter and arms the timer. The timer expires on exactly the count-th decrement.
- R4: An evt_i bit that is set in a timer's reload mask reloads that timer. An event outside the mask has no effect. A reload in the same cycle as the final decrement wins, and no expiry happens.
- R5: When timer A expires with its action bit set, clk_mode_o becomes 1 (slow). Expiry of timer A always sets status bit 0.
- R6: While the clock is slow, an evt_i bit that is set in the timer A wake mask returns clk_mode_o to 0 and sets status bit 1. Wake events that arrive while the clock is not slow are ignored.
- R7: When timer B expires with its action bit set, clk_mode_o becomes 2 and clk_stop_o becomes 1. Without the action bit, the clock is unchanged. Expiry of timer B always sets status bit 2.
- R8: While the clock is stopped, an event in the timer B wake mask (evt_i[7:0] only) restarts the clock at the speed selected last: mode 1 if timer A had slowed it, otherwise mode 0. It also sets status bit 3.
- R9: irq_o is a one-cycle pulse. It is raised only by an expiry or wake whose matching interrupt enable bit is set, and it coincides with the matching status bit being set.
- R10: A count of 0 disables the timer, so it never expires.
- R11: Writing 1 to a status bit at address 6 clears that bit. Bits written as 0 are kept. A status set in the same cycle as its clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Base time tick, one cycle per pulse |
| evt_i | input | 16 | Activity event vector; timer B sees bits 7:0 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Register write data |
| clk_mode_o | output | 2 | 0 full, 1 slow, 2 stopped |
| clk_stop_o | output | 1 | Clock stop request |
| irq_o | output | 1 | Interrupt pulse |
| status_o | output | 4 | Sticky status: A expired, A woke, B expired, B woke |

## Verification
Two pairs of functions can fall into the same cycle.

The first pair is a reload and the final decrement. The bench raises a masked event in the same cycle as the tick that would end timer A. It then expects the clock to stay at full speed, with no status bit set, and expects expiry only after a full new interval.

The second pair is both timers expiring on one tick. The bench expects the stopped state, status bits 0 and 2, and one interrupt pulse. It then expects a timer B wake to restore slow rather than full speed. A status clear issued together with a fresh expiry is also checked, and the set must survive the clear.

// File: rtl/idle_clk_pkg.sv
package idle_clk_pkg;
  typedef enum logic [1:0] {
    CLK_FULL = 2'd0,
    CLK_SLOW = 2'd1,
    CLK_STOP = 2'd2
  } clk_mode_e;

  localparam logic [2:0] ADDR_DIV    = 3'd0;
  localparam logic [2:0] ADDR_A_CFG  = 3'd1;
  localparam logic [2:0] ADDR_A_EVT  = 3'd2;
  localparam logic [2:0] ADDR_A_WAKE = 3'd3;
  localparam logic [2:0] ADDR_B_CFG  = 3'd4;
  localparam logic [2:0] ADDR_B_MASK = 3'd5;
  localparam logic [2:0] ADDR_CLR    = 3'd6;

  localparam int ST_A_EXP  = 0;
  localparam int ST_A_WAKE = 1;
  localparam int ST_B_EXP  = 2;
  localparam int ST_B_WAKE = 3;
  localparam int ST_W      = 4;
endpackage

// File: rtl/idle_tick_div.sv
module idle_tick_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             stb_o
);
  logic [DIV_W-1:0] cnt_q;

  assign stb_o = tick_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (stb_o)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] start_cnt_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pcnt_q;
  logic             armed_q;
  logic             tstb;

  assign tstb     = stb_i && armed_q && (pcnt_q >= pre_i);
  // reload beats the final decrement
  assign expire_o = tstb && !restart_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pcnt_q  <= '0;
      armed_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q   <= start_cnt_i;
      pcnt_q  <= '0;
      armed_q <= (start_cnt_i != '0);
    end else if (stb_i && armed_q) begin
      if (tstb) begin
        pcnt_q <= '0;
        cnt_q  <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) armed_q <= 1'b0;
      end else begin
        pcnt_q <= pcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/idle_clk_mgr.sv
module idle_clk_mgr
  import idle_clk_pkg::*;
#(
  parameter int EVT_A_W = 16,
  parameter int EVT_B_W = 8,
  parameter int CNT_W   = 8,
  parameter int PRE_W   = 4,
  parameter int DIV_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [EVT_A_W-1:0] evt_i,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_addr_i,
  input  logic [EVT_A_W-1:0] wr_data_i,
  output logic [1:0]         clk_mode_o,
  output logic               clk_stop_o,
  output logic               irq_o,
  output logic [ST_W-1:0]    status_o
);
  localparam int PRE_LSB = CNT_W;
  localparam int ACT_BIT = CNT_W + PRE_W;
  localparam int IRQ_EXP = ACT_BIT + 1;
  localparam int IRQ_WK  = ACT_BIT + 2;
  localparam int CFG_W   = ACT_BIT + 3;

  logic [DIV_W-1:0]   div_q;
  logic [CFG_W-1:0]   a_cfg_q, b_cfg_q;
  logic [EVT_A_W-1:0] a_evt_q, a_wake_q;
  logic [EVT_B_W-1:0] b_evt_q, b_wake_q;
  logic               slow_q, stop_q, irq_q;
  logic [ST_W-1:0]    status_q;

  logic wr_div, wr_a_cfg, wr_b_cfg;
  logic base_stb, exp_a, exp_b, wake_a, wake_b;
  logic restart_a, restart_b;
  logic [CNT_W-1:0] start_a, start_b;
  logic [ST_W-1:0]  st_set, st_clr;

  assign wr_div   = wr_en_i && (wr_addr_i == ADDR_DIV);
  assign wr_a_cfg = wr_en_i && (wr_addr_i == ADDR_A_CFG);
  assign wr_b_cfg = wr_en_i && (wr_addr_i == ADDR_B_CFG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= '0;
      a_cfg_q  <= '0;
      b_cfg_q  <= '0;
      a_evt_q  <= '0;
      a_wake_q <= '0;
      b_evt_q  <= '0;
      b_wake_q <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_DIV:    div_q    <= wr_data_i[DIV_W-1:0];
        ADDR_A_CFG:  a_cfg_q  <= wr_data_i[CFG_W-1:0];
        ADDR_A_EVT:  a_evt_q  <= wr_data_i;
        ADDR_A_WAKE: a_wake_q <= wr_data_i;
        ADDR_B_CFG:  b_cfg_q  <= wr_data_i[CFG_W-1:0];
        ADDR_B_MASK: begin
          b_evt_q  <= wr_data_i[EVT_B_W-1:0];
          b_wake_q <= wr_data_i[2*EVT_B_W-1:EVT_B_W];
        end
        default: ;
      endcase
    end
  end

  idle_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .clr_i (wr_div),
    .div_i (div_q),
    .stb_o (base_stb)
  );

  assign restart_a = wr_a_cfg || |(evt_i & a_evt_q);
  assign restart_b = wr_b_cfg || |(evt_i[EVT_B_W-1:0] & b_evt_q);
  assign start_a   = wr_a_cfg ? wr_data_i[CNT_W-1:0] : a_cfg_q[CNT_W-1:0];
  assign start_b   = wr_b_cfg ? wr_data_i[CNT_W-1:0] : b_cfg_q[CNT_W-1:0];

  idle_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_tmr_a (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stb_i      (base_stb),
    .restart_i  (restart_a),
    .start_cnt_i(start_a),
    .pre_i      (a_cfg_q[PRE_LSB +: PRE_W]),
    .expire_o   (exp_a)
  );

  idle_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_tmr_b (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stb_i      (base_stb),
    .restart_i  (restart_b),
    .start_cnt_i(start_b),
    .pre_i      (b_cfg_q[PRE_LSB +: PRE_W]),
    .expire_o   (exp_b)
  );

  assign wake_a = slow_q && |(evt_i & a_wake_q);
  assign wake_b = stop_q && |(evt_i[EVT_B_W-1:0] & b_wake_q);

  always_comb begin
    st_set            = '0;
    st_set[ST_A_EXP]  = exp_a;
    st_set[ST_A_WAKE] = wake_a;
    st_set[ST_B_EXP]  = exp_b;
    st_set[ST_B_WAKE] = wake_b;
    st_clr = (wr_en_i && (wr_addr_i == ADDR_CLR)) ? wr_data_i[ST_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slow_q   <= 1'b0;
      stop_q   <= 1'b0;
      irq_q    <= 1'b0;
      status_q <= '0;
    end else begin
      // expiry takes precedence over a wake in the same cycle
      if (exp_a && a_cfg_q[ACT_BIT]) slow_q <= 1'b1;
      else if (wake_a)               slow_q <= 1'b0;
      if (exp_b && b_cfg_q[ACT_BIT]) stop_q <= 1'b1;
      else if (wake_b)               stop_q <= 1'b0;
      irq_q <= (exp_a && a_cfg_q[IRQ_EXP]) || (wake_a && a_cfg_q[IRQ_WK]) ||
               (exp_b && b_cfg_q[IRQ_EXP]) || (wake_b && b_cfg_q[IRQ_WK]);
      status_q <= (status_q & ~st_clr) | st_set;
    end
  end

  assign clk_mode_o = stop_q ? CLK_STOP : (slow_q ? CLK_SLOW : CLK_FULL);
  assign clk_stop_o = stop_q;
  assign irq_o      = irq_q;
  assign status_o   = status_q;
endmodule

// File: rtl/idle_clk_mgr_sva.sv
module idle_clk_mgr_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] clk_mode_o,
  input logic       clk_stop_o,
  input logic       irq_o,
  input logic [3:0] status_o
);
  p_mode_enc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_mode_o != 2'd3)
    else $error("p_mode_enc_r5");

  p_slow_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clk_mode_o) == 2'd0 && clk_mode_o == 2'd1) |-> status_o[0])
    else $error("p_slow_entry_r5");

  p_stop_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_stop_o) |-> status_o[2])
    else $error("p_stop_entry_r7");

  p_stop_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_stop_o) |-> status_o[3])
    else $error("p_stop_exit_r8");

  p_irq_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_o != 4'd0))
    else $error("p_irq_cause_r9");
endmodule

bind idle_clk_mgr idle_clk_mgr_sva u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clk_mode_o(clk_mode_o),
  .clk_stop_o(clk_stop_o),
  .irq_o     (irq_o),
  .status_o  (status_o)
);

// File: tb/idle_clk_mgr_test.sv
module idle_clk_mgr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] evt = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  mode;
  logic        stop;
  logic        irq;
  logic [3:0]  status;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  idle_clk_mgr uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .evt_i(evt),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .clk_mode_o(mode), .clk_stop_o(stop), .irq_o(irq), .status_o(status)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle of stimulus, called and returning at a falling edge
  task automatic cyc(input logic w, input logic [2:0] a, input logic [15:0] d,
                     input logic t, input logic [15:0] e);
    wr_en = w; wr_addr = a; wr_data = d; tick = t; evt = e;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0; evt = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    cyc(1'b1, a, d, 1'b0, '0);
  endtask

  task automatic ticks(input int n);
    repeat (n) cyc(1'b0, 3'd0, '0, 1'b1, '0);
  endtask

  task automatic ev(input logic [15:0] e);
    cyc(1'b0, 3'd0, '0, 1'b0, e);
  endtask

  task automatic t_reset;
    check("R1 mode", mode, 0);
    check("R1 stop", stop, 0);
    check("R1 irq", irq, 0);
    check("R1 status", status, 0);
  endtask

  task automatic t_a_expire;
    wr(3'd1, 16'h3003);
    ticks(2);
    check("R3 before count", mode, 0);
    ticks(1);
    check("R3 R5 slow", mode, 1);
    check("R9 irq on expiry", irq, 1);
    check("R5 status", status, 1);
    ev('0);
    check("R9 one cycle", irq, 0);
  endtask

  task automatic t_a_wake;
    wr(3'd3, 16'h0100);
    ev(16'h0001);
    check("R6 unmasked wake ignored", mode, 1);
    ev(16'h0100);
    check("R6 wake full", mode, 0);
    check("R6 status", status, 3);
    check("R9 no wake irq", irq, 0);
    wr(3'd6, 16'h000F);
    check("R11 clear all", status, 0);
    ev(16'h0100);
    check("R6 wake when full ignored", status, 0);
  endtask

  task automatic t_reload;
    wr(3'd2, 16'h0004);
    wr(3'd1, 16'h1002);
    ticks(1);
    ev(16'h0004);
    ticks(1);
    check("R4 reload delays", mode, 0);
    ticks(1);
    check("R4 expiry after reload", mode, 1);
    ev(16'h0100); wr(3'd6, 16'h000F);
    // reload in the same cycle as the final decrement
    wr(3'd1, 16'h1002);
    ticks(1);
    cyc(1'b0, 3'd0, '0, 1'b1, 16'h0004);
    check("R4 reload wins mode", mode, 0);
    check("R4 reload wins status", status, 0);
    ticks(1);
    check("R4 new interval", mode, 0);
    ticks(1);
    check("R4 new interval end", mode, 1);
    ev(16'h0100); wr(3'd6, 16'h000F);
    wr(3'd1, 16'h1002);
    ticks(1);
    ev(16'h0008);
    check("R4 outside mask mode", mode, 0);
    ticks(1);
    check("R4 outside mask no reload", mode, 1);
    ev(16'h0100); wr(3'd6, 16'h000F);
  endtask

  task automatic t_divide;
    wr(3'd0, 16'h0001);
    wr(3'd1, 16'h1102);
    ticks(7);
    check("R2 not yet", mode, 0);
    ticks(1);
    check("R2 eight ticks", mode, 1);
    ev(16'h0100); wr(3'd6, 16'h000F); wr(3'd0, 16'h0000);
  endtask

  task automatic t_stop;
    wr(3'd2, 16'h0000);
    wr(3'd5, 16'h0100);
    wr(3'd1, 16'h1001);
    wr(3'd4, 16'h7001);
    ticks(1);
    check("R7 both expire mode", mode, 2);
    check("R7 stop", stop, 1);
    check("R7 status", status, 5);
    check("R9 irq", irq, 1);
    ev(16'h0001);
    check("R8 back to slow", mode, 1);
    check("R8 stop low", stop, 0);
    check("R8 status", status, 13);
    check("R9 wake irq", irq, 1);
    ev(16'h0100);
    check("R6 full", mode, 0);
    wr(3'd6, 16'h000F);
    wr(3'd4, 16'h1001);
    ticks(1);
    check("R7 stop from full", mode, 2);
    ev(16'h0001);
    check("R8 back to full", mode, 0);
    check("R9 wake irq disabled", irq, 0);
    wr(3'd6, 16'h000F);
    wr(3'd4, 16'h2001);
    ticks(1);
    check("R7 irq only mode", mode, 0);
    check("R7 irq only stop", stop, 0);
    check("R7 irq only status", status, 4);
    check("R9 irq only", irq, 1);
    wr(3'd6, 16'h000F);
  endtask

  task automatic t_zero;
    wr(3'd1, 16'h1000);
    wr(3'd4, 16'h1000);
    ticks(300);
    check("R10 mode", mode, 0);
    check("R10 status", status, 0);
  endtask

  task automatic t_clear;
    wr(3'd1, 16'h1001);
    ticks(1);
    wr(3'd6, 16'h0002);
    check("R11 zero bits kept", status, 1);
    ev(16'h0100);
    wr(3'd6, 16'h0001);
    check("R11 partial clear", status, 2);
    wr(3'd1, 16'h1001);
    cyc(1'b1, 3'd6, 16'h0001, 1'b1, '0);
    check("R11 set wins", status, 3);
    ev(16'h0100); wr(3'd6, 16'h000F);
    check("R11 cleared", status, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_a_expire();
    t_a_wake();
    t_reload();
    t_divide();
    t_stop();
    t_zero();
    t_clear();
    finish_run();
  end
endmodule